// File: doc/BRIEF.md
# Program Fetch Memory Router

This block sits between a small microcontroller core's instruction-fetch port and two code stores: an on-chip code ROM and an off-chip code memory. Each fetch carries a 16-bit byte address. The block decides which store serves it and returns one byte with a one-cycle valid pulse. For off-chip fetches it also drives an active-low read strobe and the fetch address.

A board-level strap input controls routing. With the strap high, the low 4K bytes (0000H to 0FFFH) come from the internal ROM and everything above goes off-chip. With the strap low, every fetch goes off-chip, the low range included.

Internal fetches complete one cycle after acceptance. Off-chip fetches complete a fixed `EXT_LAT` cycles after acceptance. Only one off-chip fetch can be outstanding at a time. The internal ROM array has a byte-wide load port so that a test environment can fill it.

Top module: `fetch_mem_router`

## Requirements
- R1: After reset, `ext_rd_n` is 1, `fetch_valid` is 0 and `fetch_rdy` is 1.
- R2: With `strap_int_en`=1, a fetch accepted at an address below 1000H returns the byte last loaded at that ROM address, with `fetch_valid`=1 and `fetch_ext`=0 in the cycle after acceptance.
- R3: `ext_rd_n` stays 1 in every cycle of an internally served fetch, including a run of back-to-back internal fetches with `fetch_req` held high.
- R4: With `strap_int_en`=1, a fetch at address 1000H or above is served off-chip.
- R5: With `strap_int_en`=0, every fetch is served off-chip, including addresses 0000H to 0FFFH.
- R6: An off-chip fetch accepted at edge T drives `ext_rd_n`=0 and `ext_addr` equal to the fetch address for the `EXT_LAT`-1 cycles after T. It samples `ext_data_in` in the last of those cycles. It returns that byte with `fetch_valid`=1 and `fetch_ext`=1 exactly `EXT_LAT` cycles after T (default `EXT_LAT`=2), and `ext_rd_n` is 1 again in that cycle.
- R7: While an off-chip fetch is outstanding, `fetch_rdy` is 0 and a `fetch_req` in that window is ignored: it yields no extra valid pulse.
- R8: Each accepted fetch produces exactly one single-cycle `fetch_valid` pulse, and never from both stores at once.
- R9: A write on the load port (`rom_ld_en`=1) stores `rom_ld_data` at `rom_ld_addr`, visible to later internal fetches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| strap_int_en | input | 1 | 1: low range served from internal ROM; 0: all fetches off-chip |
| fetch_req | input | 1 | Fetch request |
| fetch_addr | input | 16 | Fetch byte address |
| fetch_rdy | output | 1 | Request accepted when high |
| fetch_valid | output | 1 | Returned byte valid (single cycle) |
| fetch_data | output | 8 | Returned byte |
| fetch_ext | output | 1 | Returned byte came from off-chip memory |
| ext_rd_n | output | 1 | Off-chip read strobe, active low |
| ext_addr | output | 16 | Off-chip code address |
| ext_data_in | input | 8 | Off-chip code byte |
| rom_ld_en | input | 1 | ROM load write enable |
| rom_ld_addr | input | 12 | ROM load address |
| rom_ld_data | input | 8 | ROM load data |

## Verification
Several properties are checked by assertions on every cycle:
- the strobe stays high after any internally routed acceptance;
- the strobe goes low after any acceptance with the strap low or with an address above the ROM;
- the off-chip address is stable while the strobe is low;
- valid pulses are single-cycle and never come from both sources at once;
- a request refused while busy produces no internal read.

Only the bench's scenarios can show that the returned bytes match the loaded ROM contents and the off-chip data, that the off-chip latency is exact, and that a request made while busy is truly lost rather than served later.

// File: rtl/fpr_pkg.sv
package fpr_pkg;
   typedef enum logic {
      SRC_INT = 1'b0,
      SRC_EXT = 1'b1
   } fetch_src_e;
endpackage

// File: rtl/fpr_route_dec.sv
module fpr_route_dec
   import fpr_pkg::*;
#(
   parameter int CODE_AW = 16,
   parameter int ROM_AW  = 12
) (
   input  logic               strap_int_en,
   input  logic [CODE_AW-1:0] addr,
   output fetch_src_e         src
);
   generate
      if (ROM_AW < CODE_AW) begin : g_partial
         logic above_rom;
         assign above_rom = |addr[CODE_AW-1:ROM_AW];
         assign src = (!strap_int_en || above_rom) ? SRC_EXT : SRC_INT;
      end else begin : g_full
         assign src = strap_int_en ? SRC_INT : SRC_EXT;
      end
   endgenerate
endmodule

// File: rtl/fpr_int_rom.sv
module fpr_int_rom #(
   parameter int ROM_AW = 12,
   parameter int DW     = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld_en,
   input  logic [ROM_AW-1:0] ld_addr,
   input  logic [DW-1:0]     ld_data,
   input  logic              rd_en,
   input  logic [ROM_AW-1:0] rd_addr,
   output logic              rd_vld,
   output logic [DW-1:0]     rd_q
);
   localparam int DEPTH = 1 << ROM_AW;

   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (ld_en) mem[ld_addr] <= ld_data;
      if (rd_en) rd_q <= mem[rd_addr];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) rd_vld <= 1'b0;
      else        rd_vld <= rd_en;
   end
endmodule

// File: rtl/fpr_ext_seq.sv
module fpr_ext_seq #(
   parameter int CODE_AW = 16,
   parameter int DW      = 8,
   parameter int EXT_LAT = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [CODE_AW-1:0] start_addr,
   input  logic [DW-1:0]      ext_din,
   output logic               busy,
   output logic               rd_n,
   output logic [CODE_AW-1:0] addr_o,
   output logic               vld,
   output logic [DW-1:0]      q
);
   localparam int CW = $clog2(EXT_LAT + 1);
   localparam logic [CW-1:0] STROBE_CYC = CW'(EXT_LAT - 1);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy   <= 1'b0;
         cnt    <= '0;
         addr_o <= '0;
         vld    <= 1'b0;
         q      <= '0;
      end else begin
         vld <= 1'b0;
         if (start) begin
            busy   <= 1'b1;
            addr_o <= start_addr;
            cnt    <= STROBE_CYC;
         end else if (busy) begin
            if (cnt == CW'(1)) begin
               busy <= 1'b0;
               vld  <= 1'b1;
               q    <= ext_din;
               cnt  <= '0;
            end else begin
               cnt <= cnt - CW'(1);
            end
         end
      end
   end

   assign rd_n = !busy;

   AST_EXT_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_n && $past(!rd_n)) |-> $stable(addr_o)); // R6
   AST_EXT_VLD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      vld |=> !vld); // R8
endmodule

// File: rtl/fetch_mem_router.sv
module fetch_mem_router
   import fpr_pkg::*;
#(
   parameter int CODE_AW = 16,
   parameter int ROM_AW  = 12,
   parameter int DW      = 8,
   parameter int EXT_LAT = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               strap_int_en,
   input  logic               fetch_req,
   input  logic [CODE_AW-1:0] fetch_addr,
   output logic               fetch_rdy,
   output logic               fetch_valid,
   output logic [DW-1:0]      fetch_data,
   output logic               fetch_ext,
   output logic               ext_rd_n,
   output logic [CODE_AW-1:0] ext_addr,
   input  logic [DW-1:0]      ext_data_in,
   input  logic               rom_ld_en,
   input  logic [ROM_AW-1:0]  rom_ld_addr,
   input  logic [DW-1:0]      rom_ld_data
);
   generate
      if (ROM_AW < 1 || ROM_AW > CODE_AW) begin : g_bad_rom
         $error("ROM_AW must lie in 1..CODE_AW");
      end
      if (EXT_LAT < 2) begin : g_bad_lat
         $error("EXT_LAT must be at least 2");
      end
      if (DW < 1) begin : g_bad_dw
         $error("DW must be positive");
      end
   endgenerate

   fetch_src_e   src;
   logic         accept, int_start, ext_start, ext_busy;
   logic         int_vld, ext_vld;
   logic [DW-1:0] int_q, ext_q;

   fpr_route_dec #(.CODE_AW(CODE_AW), .ROM_AW(ROM_AW)) u_dec (
      .strap_int_en (strap_int_en),
      .addr         (fetch_addr),
      .src          (src)
   );

   assign fetch_rdy = !ext_busy;
   assign accept    = fetch_req && fetch_rdy;
   assign int_start = accept && (src == SRC_INT);
   assign ext_start = accept && (src == SRC_EXT);

   fpr_int_rom #(.ROM_AW(ROM_AW), .DW(DW)) u_rom (
      .clk     (clk),
      .rst_n   (rst_n),
      .ld_en   (rom_ld_en),
      .ld_addr (rom_ld_addr),
      .ld_data (rom_ld_data),
      .rd_en   (int_start),
      .rd_addr (fetch_addr[ROM_AW-1:0]),
      .rd_vld  (int_vld),
      .rd_q    (int_q)
   );

   fpr_ext_seq #(.CODE_AW(CODE_AW), .DW(DW), .EXT_LAT(EXT_LAT)) u_ext (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (ext_start),
      .start_addr (fetch_addr),
      .ext_din    (ext_data_in),
      .busy       (ext_busy),
      .rd_n       (ext_rd_n),
      .addr_o     (ext_addr),
      .vld        (ext_vld),
      .q          (ext_q)
   );

   assign fetch_valid = int_vld || ext_vld;
   assign fetch_ext   = ext_vld;
   assign fetch_data  = ext_vld ? ext_q : int_q;

   AST_INT_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      int_start |=> ext_rd_n); // R3
   AST_STRAP_LOW_EXT: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && !strap_int_en) |=> !ext_rd_n); // R5
   AST_HIGH_ADDR_EXT: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && ((fetch_addr >> ROM_AW) != '0)) |=> !ext_rd_n); // R4
   AST_ONE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({int_vld, ext_vld})); // R8
   AST_BUSY_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_req && ext_busy) |=> !int_vld); // R7
endmodule

// File: tb/tb_fetch_mem_router.sv
module tb_fetch_mem_router;
   localparam int EXT_LAT = 2;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        strap_int_en;
   logic        fetch_req;
   logic [15:0] fetch_addr;
   logic        fetch_rdy, fetch_valid, fetch_ext, ext_rd_n;
   logic [7:0]  fetch_data;
   logic [15:0] ext_addr;
   logic [7:0]  ext_data_in;
   logic        rom_ld_en;
   logic [11:0] rom_ld_addr;
   logic [7:0]  rom_ld_data;

   int checks = 0;
   int fails  = 0;

   always #2 clk = ~clk;

   function automatic logic [7:0] rom_pat(input logic [15:0] a);
      return 8'(a[7:0] * 3 + a[11:8]);
   endfunction
   function automatic logic [7:0] ext_pat(input logic [15:0] a);
      return a[7:0] ^ a[15:8] ^ 8'hA5;
   endfunction

   assign ext_data_in = ext_pat(ext_addr);

   fetch_mem_router #(.EXT_LAT(EXT_LAT)) dut (
      .clk(clk), .rst_n(rst_n), .strap_int_en(strap_int_en),
      .fetch_req(fetch_req), .fetch_addr(fetch_addr), .fetch_rdy(fetch_rdy),
      .fetch_valid(fetch_valid), .fetch_data(fetch_data), .fetch_ext(fetch_ext),
      .ext_rd_n(ext_rd_n), .ext_addr(ext_addr), .ext_data_in(ext_data_in),
      .rom_ld_en(rom_ld_en), .rom_ld_addr(rom_ld_addr), .rom_ld_data(rom_ld_data)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // One fetch: {strap, addr}; the expected route follows R2, R4 and R5.
   task automatic do_fetch(input logic strap, input logic [15:0] a);
      bit is_ext;
      is_ext = !strap || (a >= 16'h1000);
      @(negedge clk);
      strap_int_en = strap;
      fetch_req    = 1'b1;
      fetch_addr   = a;
      chk(fetch_rdy == 1'b1, "R7", "rdy before request", int'(fetch_rdy), 1);
      @(negedge clk);
      fetch_req = 1'b0;
      if (!is_ext) begin
         chk(fetch_valid == 1'b1, "R2", "int valid", int'(fetch_valid), 1);
         chk(fetch_data == rom_pat(a), "R2", "int data", int'(fetch_data), int'(rom_pat(a)));
         chk(fetch_ext == 1'b0, "R2", "int source", int'(fetch_ext), 0);
         chk(ext_rd_n == 1'b1, "R3", "no strobe on int", int'(ext_rd_n), 1);
      end else begin
         for (int k = 1; k < EXT_LAT; k++) begin
            chk(ext_rd_n == 1'b0, strap ? "R4" : "R5", "strobe low", int'(ext_rd_n), 0);
            chk(ext_addr == a, "R6", "ext addr", int'(ext_addr), int'(a));
            chk(fetch_valid == 1'b0, "R6", "no early valid", int'(fetch_valid), 0);
            @(negedge clk);
         end
         chk(fetch_valid == 1'b1, "R6", "ext valid", int'(fetch_valid), 1);
         chk(fetch_ext == 1'b1, "R6", "ext source", int'(fetch_ext), 1);
         chk(fetch_data == ext_pat(a), "R6", "ext data", int'(fetch_data), int'(ext_pat(a)));
         chk(ext_rd_n == 1'b1, "R6", "strobe released", int'(ext_rd_n), 1);
      end
      @(negedge clk);
      chk(fetch_valid == 1'b0, "R8", "single pulse", int'(fetch_valid), 0);
   endtask

   localparam int NV = 8;
   localparam logic [16:0] VEC [NV] = '{
      {1'b1, 16'h0000}, {1'b1, 16'h0FFF}, {1'b1, 16'h0123}, {1'b1, 16'h1000},
      {1'b1, 16'hFFFF}, {1'b0, 16'h0000}, {1'b0, 16'h0123}, {1'b0, 16'h0FFF}
   };

   initial begin
      #400000;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      rst_n = 1'b0; strap_int_en = 1'b1; fetch_req = 1'b0; fetch_addr = '0;
      rom_ld_en = 1'b0; rom_ld_addr = '0; rom_ld_data = '0;
      repeat (3) @(negedge clk);
      chk(ext_rd_n == 1'b1, "R1", "reset strobe", int'(ext_rd_n), 1);
      chk(fetch_valid == 1'b0, "R1", "reset valid", int'(fetch_valid), 0);
      chk(fetch_rdy == 1'b1, "R1", "reset rdy", int'(fetch_rdy), 1);
      // R9: fill the ROM through the load port
      for (int i = 0; i < 4096; i++) begin
         rom_ld_en = 1'b1; rom_ld_addr = 12'(i); rom_ld_data = rom_pat(16'(i));
         @(negedge clk);
      end
      rom_ld_en = 1'b0;
      rst_n = 1'b1;
      @(negedge clk);

      for (int v = 0; v < NV; v++) do_fetch(VEC[v][16], VEC[v][15:0]);

      // R3: back-to-back internal fetches with request held
      @(negedge clk);
      strap_int_en = 1'b1; fetch_req = 1'b1; fetch_addr = 16'h0010;
      for (int j = 1; j <= 3; j++) begin
         @(negedge clk);
         chk(fetch_valid == 1'b1, "R3", "b2b valid", int'(fetch_valid), 1);
         chk(fetch_data == rom_pat(16'h0010 + 16'(j - 1)), "R3", "b2b data",
             int'(fetch_data), int'(rom_pat(16'h0010 + 16'(j - 1))));
         chk(ext_rd_n == 1'b1, "R3", "b2b strobe high", int'(ext_rd_n), 1);
         fetch_addr = 16'h0010 + 16'(j);
      end
      fetch_req = 1'b0;
      @(negedge clk);

      // R7: request while an off-chip fetch is outstanding is dropped
      fetch_req = 1'b1; fetch_addr = 16'h2345;
      @(negedge clk);
      chk(fetch_rdy == 1'b0, "R7", "busy rdy", int'(fetch_rdy), 0);
      fetch_addr = 16'h0042;
      @(negedge clk);
      fetch_req = 1'b0;
      chk(fetch_data == ext_pat(16'h2345), "R7", "first served",
          int'(fetch_data), int'(ext_pat(16'h2345)));
      @(negedge clk);
      chk(fetch_valid == 1'b0, "R7", "dropped req no valid", int'(fetch_valid), 0);
      @(negedge clk);
      chk(fetch_valid == 1'b0, "R7", "still no valid", int'(fetch_valid), 0);

      // R9: overwrite one ROM byte and fetch it
      rom_ld_en = 1'b1; rom_ld_addr = 12'h0AB; rom_ld_data = 8'h3C;
      @(negedge clk);
      rom_ld_en = 1'b0;
      strap_int_en = 1'b1; fetch_req = 1'b1; fetch_addr = 16'h00AB;
      @(negedge clk);
      fetch_req = 1'b0;
      chk(fetch_data == 8'h3C, "R9", "reloaded byte", int'(fetch_data), 8'h3C);

      // R1: reset mid-fetch returns to idle
      fetch_req = 1'b1; fetch_addr = 16'h8000;
      @(negedge clk);
      fetch_req = 1'b0; rst_n = 1'b0;
      @(negedge clk);
      chk(ext_rd_n == 1'b1, "R1", "reset clears strobe", int'(ext_rd_n), 1);
      chk(fetch_valid == 1'b0, "R1", "reset clears valid", int'(fetch_valid), 0);
      chk(fetch_rdy == 1'b1, "R1", "reset rdy", int'(fetch_rdy), 1);

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule